// File: doc/BRIEF.md
# Oversampled Two-Lane Arrival Skew Meter

This block measures the time between the arrivals of two signals whose levels are sampled by high-rate deserializers. Every clock it takes one parallel word per lane; each word carries `WORD_W` consecutive serial samples, and each sample stands for one unit interval (200 ps at a 5 Gb/s sampling rate). Typical formats are 20 samples at 250 MHz or 16 samples at 312.5 MHz. A 32-sample word at 156.25 MHz, produced by a widening stage in front of the block, works the same way. Only `WORD_W` changes; the resolution per sample does not.

Software or a sequencer arms the block. From then on the block counts words. In each lane it finds the first 0-to-1 transition and resolves it to one sample inside the word, and it forms a timestamp from the word count and the sample index. When both lanes have a timestamp, the block gives out the signed skew in sample units, lane B minus lane A, less a programmable offset. The offset cancels the fixed latency mismatch between the two capture paths. If an arrival does not come within a programmable number of words, the block flags a timeout.

Top module: `skew_meter`

## Requirements
- R1: After reset, `busy`, `result_valid` and `timeout` are low and `result` is zero.
- R2: Bit 0 of a word is the earliest sample. A rising edge at bit i means bit i is 1 and the sample before it is 0. For bit 0 the sample before it is bit `WORD_W-1` of the previous word, and this bit is tracked even while idle. A lane that is already high when the block is armed therefore shows no edge.
- R3: An `arm` pulse sampled on a clock edge sets `busy`. The word presented in the next cycle is word 0, and each later word adds one. An edge timestamp is word number × `WORD_W` + bit index.
- R4: After arming, only the first rising edge of each lane is kept. Later edges, including edges after the lane falls again, do not change the result.
- R5: One cycle after the clock edge that takes in the word completing the second lane, `result_valid` is high for exactly one cycle. At that point `result` = tsB − tsA − `lat_offset` (two's complement) and `busy` is low.
- R6: When both edges lie in the same word, the result follows from the bit indices alone. It is correct for positive, zero and negative values.
- R7: With `tmo_words` = N, the block examines words 0 to N−1 (N = 0 means 65536). If no result has completed by then, `timeout` pulses for one cycle after word N−1 and `busy` falls. `timeout` and `result_valid` are never high together.
- R8: A `clear` pulse returns the block to idle at once and produces neither pulse. `clear` takes priority over `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart a measurement |
| clear | input | 1 | Abort and go idle |
| lat_offset | input | OFS_W | Signed lane latency correction, in samples |
| tmo_words | input | CNT_W | Number of words examined before timeout |
| word_a | input | WORD_W | Lane A samples, bit 0 earliest |
| word_b | input | WORD_W | Lane B samples, bit 0 earliest |
| busy | output | 1 | Measurement in progress |
| result_valid | output | 1 | One-cycle result strobe |
| result | output | DIFF_W | Signed skew, in samples |
| timeout | output | 1 | One-cycle timeout strobe |

## Verification
The hardest situation to reach from the ports is a lane that rises, falls and rises again before the other lane arrives. Only the first edge may count, and the word boundary makes the fall land on bit 0 against the previous word's last bit. The bench builds that waveform across two words and places the other lane's edge a word later. A second hard case is a lane already high at arming. It is produced by holding the lane high through the arm cycle, so that the bit-0 comparison against the idle-tracked sample is exercised.

// File: rtl/skew_pkg.sv
package skew_pkg;
   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_ARMED = 1'b1
   } meter_state_t;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/skew_edge_find.sv
module skew_edge_find #(
   parameter int WORD_W = 20,
   localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic              prev_bit,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   logic [WORD_W-1:0] rise;

   initial begin
      assert (WORD_W >= 2) else $error("WORD_W must be at least 2");
   end

   genvar g;
   generate
      for (g = 0; g < WORD_W; g++) begin : g_rise
         if (g == 0) begin : g_first
            assign rise[g] = word[g] & ~prev_bit;
         end else begin : g_rest
            assign rise[g] = word[g] & ~word[g-1];
         end
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         if (rise[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/skew_lane.sv
module skew_lane #(
   parameter int WORD_W = 20,
   parameter int CNT_W  = 16,
   localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1,
   localparam int TS_W  = CNT_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              enable,
   input  logic              restart,
   output logic              hit_now,
   output logic [TS_W-1:0]   ts_now,
   output logic              got,
   output logic [TS_W-1:0]   ts_held
);
   logic             prev_bit;
   logic [IDX_W-1:0] idx;

   skew_edge_find #(.WORD_W(WORD_W)) u_find (
      .word(word), .prev_bit(prev_bit), .hit(hit_now), .idx(idx)
   );

   assign ts_now = TS_W'(cnt) * TS_W'(WORD_W) + TS_W'(idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_bit <= 1'b0;
         got      <= 1'b0;
         ts_held  <= '0;
      end else begin
         prev_bit <= word[WORD_W-1];
         if (restart) begin
            got <= 1'b0;
         end else if (enable && hit_now && !got) begin
            got     <= 1'b1;
            ts_held <= ts_now;
         end
      end
   end

   // R2: a reported edge always points at a high sample
   a_r2_hit_high: assert property (@(posedge clk) disable iff (!rst_n)
      hit_now |-> word[idx]);
   // R4: a captured stamp is kept until restart
   a_r4_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
      (got && !restart) |=> (got && $stable(ts_held)));
endmodule

// File: rtl/skew_ctrl.sv
module skew_ctrl
   import skew_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             clear,
   input  logic             both,
   input  logic [CNT_W-1:0] tmo_words,
   output logic             armed,
   output logic             finish,
   output logic [CNT_W-1:0] cnt,
   output logic             result_valid,
   output logic             timeout
);
   meter_state_t     state;
   logic [CNT_W-1:0] cnt_nx;

   initial begin
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
   end

   assign armed  = (state == ST_ARMED);
   assign cnt_nx = cnt + 1'b1;
   assign finish = armed && both && !arm && !clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         cnt          <= '0;
         result_valid <= 1'b0;
         timeout      <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         timeout      <= 1'b0;
         if (clear) begin
            state <= ST_IDLE;
         end else if (arm) begin
            state <= ST_ARMED;
            cnt   <= '0;
         end else if (armed) begin
            cnt <= cnt_nx;
            if (both) begin
               state        <= ST_IDLE;
               result_valid <= 1'b1;
            end else if (cnt_nx == tmo_words) begin
               state   <= ST_IDLE;
               timeout <= 1'b1;
            end
         end
      end
   end

   // R3: the word counter steps by one per armed word
   a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !arm && !clear) |=> (cnt == $past(cnt_nx)));
   // R5: the result strobe lasts one cycle and leaves the block idle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   a_r5_idle_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !armed);
   // R7: timeout and result are exclusive, timeout is one cycle
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(result_valid && timeout));
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);
   // R8: clear always ends in idle without a strobe
   a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!armed && !result_valid && !timeout));
endmodule

// File: rtl/skew_meter.sv
module skew_meter
   import skew_pkg::*;
#(
   parameter int WORD_W = 20,
   parameter int CNT_W  = 16,
   parameter int OFS_W  = 12,
   localparam int IDX_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1,
   localparam int TS_W   = CNT_W + IDX_W,
   localparam int DIFF_W = max_i(TS_W, OFS_W) + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm,
   input  logic                     clear,
   input  logic signed [OFS_W-1:0]  lat_offset,
   input  logic [CNT_W-1:0]         tmo_words,
   input  logic [WORD_W-1:0]        word_a,
   input  logic [WORD_W-1:0]        word_b,
   output logic                     busy,
   output logic                     result_valid,
   output logic signed [DIFF_W-1:0] result,
   output logic                     timeout
);
   localparam int LANES = 2;

   initial begin
      assert (OFS_W >= 2) else $error("OFS_W must be at least 2");
   end

   logic [WORD_W-1:0] lane_word [LANES];
   logic [LANES-1:0]  hit_now, got, avail;
   logic [TS_W-1:0]   ts_now [LANES];
   logic [TS_W-1:0]   ts_held [LANES];
   logic [TS_W-1:0]   ts_eff [LANES];
   logic              armed, finish, both;
   logic [CNT_W-1:0]  cnt;
   logic signed [DIFF_W-1:0] diff_now;

   assign lane_word[0] = word_a;
   assign lane_word[1] = word_b;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         skew_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .word(lane_word[g]), .cnt(cnt),
            .enable(armed), .restart(arm | clear),
            .hit_now(hit_now[g]), .ts_now(ts_now[g]),
            .got(got[g]), .ts_held(ts_held[g])
         );
         assign avail[g]  = got[g] | (hit_now[g] & armed);
         assign ts_eff[g] = got[g] ? ts_held[g] : ts_now[g];
      end
   endgenerate

   assign both = &avail;

   skew_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear), .both(both),
      .tmo_words(tmo_words), .armed(armed), .finish(finish), .cnt(cnt),
      .result_valid(result_valid), .timeout(timeout)
   );

   assign busy = armed;

   assign diff_now = $signed({2'b00, ts_eff[1]}) - $signed({2'b00, ts_eff[0]})
                   - DIFF_W'(lat_offset);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
      end else if (finish) begin
         result <= diff_now;
      end
   end

   // R5: result changes only together with a strobe
   a_r5_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> $stable(result) || $past(!rst_n));
endmodule

// File: tb/sim_skew_meter.sv
module sim_skew_meter;
   localparam time CLK_PERIOD = 4ns;
   localparam int W = 20;
   localparam int DW = 23;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, clear = 1'b0;
   logic signed [11:0] lat_offset = '0;
   logic [15:0] tmo_words = 16'd30;
   logic [W-1:0] word_a = '0, word_b = '0;
   logic busy, result_valid, timeout;
   logic signed [DW-1:0] result;

   int checks = 0, errors = 0;

   skew_meter u0 (
      .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear),
      .lat_offset(lat_offset), .tmo_words(tmo_words),
      .word_a(word_a), .word_b(word_b), .busy(busy),
      .result_valid(result_valid), .result(result), .timeout(timeout)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // columns: word A, bit A, word B, bit B, offset
   localparam int NV = 8;
   localparam int VEC [NV][5] = '{
      '{0, 5, 0, 12, 0},
      '{0, 12, 0, 5, 0},
      '{0, 7, 0, 7, 0},
      '{2, 19, 3, 0, 0},
      '{1, 0, 4, 3, 10},
      '{5, 10, 0, 0, -3},
      '{0, 0, 0, 19, 19},
      '{3, 4, 3, 4, -5}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] rise_word(input int k, input int wn, input int b);
      if (k < wn) return '0;
      if (k == wn) return {W{1'b1}} << b;
      return {W{1'b1}};
   endfunction

   task automatic do_arm(input logic a_pre);
      @(negedge clk);
      word_a = {W{a_pre}};
      word_b = '0;
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   // walk words until a strobe; returns word index and kind (1 valid, 2 timeout)
   task automatic run_edges(input int wa, input int ba, input int wb, input int bb,
                            output int k_hit, output int kind);
      k_hit = -1;
      kind = 0;
      for (int k = 0; k < 40; k++) begin
         word_a = rise_word(k, wa, ba);
         word_b = rise_word(k, wb, bb);
         @(negedge clk);
         if (result_valid || timeout) begin
            k_hit = k;
            kind = result_valid ? 1 : 2;
            break;
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int k_hit, kind, exp;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", int'(busy), 0);
      check("R1 result_valid", int'(result_valid), 0);
      check("R1 timeout", int'(timeout), 0);
      check("R1 result", int'(result), 0);
      rst_n = 1'b1;

      // table of vectors (R3, R5, R6)
      for (int v = 0; v < NV; v++) begin
         lat_offset = 12'(VEC[v][4]);
         tmo_words = 16'd30;
         do_arm(1'b0);
         check("R3 busy after arm", int'(busy), 1);
         run_edges(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], k_hit, kind);
         exp = (VEC[v][2] * W + VEC[v][3]) - (VEC[v][0] * W + VEC[v][1]) - VEC[v][4];
         check("R5 strobe kind", kind, 1);
         check("R5 strobe word", k_hit,
               (VEC[v][0] > VEC[v][2]) ? VEC[v][0] : VEC[v][2]);
         if (VEC[v][0] == VEC[v][2]) check("R6 same-word result", int'(result), exp);
         else check("R3 timestamp result", int'(result), exp);
         check("R5 busy low", int'(busy), 0);
         @(negedge clk);
         check("R5 one-cycle strobe", int'(result_valid), 0);
         word_a = '0;
         word_b = '0;
      end

      // R4: A rises, falls at bit 0 of word 1, rises again at bit 10
      lat_offset = '0;
      do_arm(1'b0);
      word_a = {W{1'b1}} << 3;
      word_b = '0;
      @(negedge clk);
      word_a = {W{1'b1}} << 10;
      @(negedge clk);
      word_a = {W{1'b1}};
      word_b = {W{1'b1}};
      @(negedge clk);
      check("R4 strobe", int'(result_valid), 1);
      check("R4 first edge kept", int'(result), 40 - 3);

      // R7: timeout after tmo_words words
      tmo_words = 16'd6;
      word_a = '0;
      word_b = '0;
      do_arm(1'b0);
      run_edges(1, 0, 99, 0, k_hit, kind);
      check("R7 timeout kind", kind, 2);
      check("R7 timeout word", k_hit, 5);
      check("R7 busy low", int'(busy), 0);
      @(negedge clk);
      check("R7 one-cycle timeout", int'(timeout), 0);

      // R2: lane A high through arming yields no edge
      tmo_words = 16'd4;
      do_arm(1'b1);
      kind = 0;
      k_hit = -1;
      for (int k = 0; k < 10; k++) begin
         word_a = {W{1'b1}};
         word_b = rise_word(k, 1, 4);
         @(negedge clk);
         if (result_valid || timeout) begin
            k_hit = k;
            kind = result_valid ? 1 : 2;
            break;
         end
      end
      check("R2 no edge when already high", kind, 2);
      check("R2 timeout word", k_hit, 3);

      // R8: clear aborts without a strobe
      tmo_words = 16'd30;
      word_a = '0;
      do_arm(1'b0);
      word_a = {W{1'b1}} << 2;
      word_b = '0;
      @(negedge clk);
      clear = 1'b1;
      word_a = {W{1'b1}};
      word_b = {W{1'b1}};
      @(negedge clk);
      clear = 1'b0;
      check("R8 no result on clear", int'(result_valid), 0);
      check("R8 idle after clear", int'(busy), 0);
      kind = 0;
      repeat (4) begin
         @(negedge clk);
         if (result_valid || timeout) kind = 1;
      end
      check("R8 no later strobe", kind, 0);
      check("R8 result held", int'(result), 37);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule